// File: doc/BRIEF.md
# Video Field Timing Generator

This block produces the field-level timing of a composite video encoder running at a 50 Hz or 60 Hz field rate. A sample counter divides the pixel clock into half lines. A half-line counter steps through one field, and a small state machine tracks odd and even fields and keeps a running field count. The half line is the basic unit throughout. Interlaced fields therefore come out at an odd number of half lines, and non-interlaced fields at an even number.

A 2-bit field length code picks one of three formats. The first is interlaced. The other two are non-interlaced, one a half line shorter than the interlaced field and one a half line longer. An external vertical reference can pull the generator into step. On a rising edge of that reference, the half-line counter is loaded with a 5-bit trigger value. This moves every derived timing signal earlier by that many half lines. The outputs are the half-line index, the line index, the field count, a field-start strobe, an odd-field flag and a vertical blanking flag. Control values come in on plain input ports.

Top module: `vid_field_timer`

## Requirements
- R1: During and directly after reset, `half_line`, `line_num`, `field_cnt` and `odd_field` are all 0, and both `field_start` and `vblank` are 1.
- R2: `half_line` goes up by one every `SAMPLES_PER_HALF` clocks. `line_num` always equals `half_line` divided by two, rounded down.
- R3: Field length code 2'b00 selects interlaced fields. A field is 625 half lines when `rate_60`=0 and 525 half lines when `rate_60`=1. `odd_field` inverts at each field wrap.
- R4: Field length code 2'b01 selects non-interlaced fields of 624 half lines (50 Hz) or 524 half lines (60 Hz). `odd_field` does not change at a wrap.
- R5: Field length codes 2'b10 and 2'b11 both select non-interlaced fields of 626 half lines (50 Hz) or 526 half lines (60 Hz). `odd_field` does not change at a wrap.
- R6: `field_start` is 1 exactly while the half-line and sample positions are both 0. `field_cnt` goes up by one, modulo 2^`FIELD_W`, at every field wrap.
- R7: `vblank` is 1 while `half_line` < `VBL_HALF_LINES` and 0 otherwise.
- R8: A rising edge of `vref_in`, sampled at a clock edge, loads `half_line` with `vtrig` (0 to 31) and resets the sample position to 0. The next field start then comes (N − `vtrig`) half lines later, where N is the current field length. A change of `vtrig` without an edge has no effect, and holding `vref_in` high gives no further reloads.
- R9: When a reload and a field wrap fall on the same clock edge, the reload wins. `odd_field` and `field_cnt` keep their values.
- R10: If the field length changes so that `half_line` is already at or past the new last half line, the next half-line step wraps the field to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rate_60 | input | 1 | 0 = 50 Hz line counts, 1 = 60 Hz line counts |
| fl_code | input | 2 | Field length code (00 interlaced, 01 short, 1x long) |
| vtrig | input | 5 | Vertical trigger phase in half lines |
| vref_in | input | 1 | External vertical reference; a rising edge reloads |
| half_line | output | 10 | Half-line index within the field |
| line_num | output | 9 | Line index within the field |
| field_cnt | output | FIELD_W | Running field count |
| field_start | output | 1 | High while the field origin is current |
| odd_field | output | 1 | Odd/even field flag |
| vblank | output | 1 | Vertical blanking flag |

## Verification
The risky coincidence is a reference edge landing on the same clock edge as the natural end of a field. Two outcomes compete there: the wrap would invert parity and bump the field count, while the reload moves the position. The bench runs a field up to its last sample and raises `vref_in` right before the wrap edge. It then checks that `half_line` took the trigger value and that `odd_field` and `field_cnt` did not change. A second coincidence follows: a change of field length that leaves the counter beyond the new end. This is judged by the wrap taking place on the very next half-line step.

// File: rtl/vft_pkg.sv
// Package: shared widths and field-length decode for the field timing generator.
// Assumes all field lengths fit in HL_W bits.
package vft_pkg;

    localparam int HL_W   = 10;
    localparam int TRIG_W = 5;

    typedef enum logic [1:0] {
        FLEN_INTERLACED = 2'b00,
        FLEN_SHORT      = 2'b01,
        FLEN_LONG_A     = 2'b10,
        FLEN_LONG_B     = 2'b11
    } flen_e;

    // Number of half lines in one field for a given rate and length code.
    function automatic logic [HL_W-1:0] field_half_lines(input logic rate_60,
                                                         input logic [1:0] code);
        logic [HL_W-1:0] base;
        base = rate_60 ? HL_W'(525) : HL_W'(625);
        case (flen_e'(code))
            FLEN_INTERLACED: return base;
            FLEN_SHORT:      return base - HL_W'(1);
            default:         return base + HL_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/vft_vref_edge.sv
// Module: rising-edge detector for the external vertical reference.
// Assumes vref_in is already synchronous to clk.
module vft_vref_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic vref_in,
    output logic vref_rise
);

    logic vref_q;

    // Remember the previous reference level.
    always_ff @(posedge clk) begin
        if (!rst_n) vref_q <= 1'b0;
        else        vref_q <= vref_in;
    end

    // A rise is high now, low on the previous edge.
    assign vref_rise = vref_in & ~vref_q;

endmodule

// File: rtl/vft_sample_ctr.sv
// Module: divides the pixel clock into half lines.
// Assumes SAMPLES_PER_HALF >= 2. A reload realigns to sample 0.
module vft_sample_ctr #(
    parameter int SAMPLES_PER_HALF = 432,
    localparam int SMP_W = $clog2(SAMPLES_PER_HALF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    output logic [SMP_W-1:0] smp,
    output logic             hl_tick
);

    localparam logic [SMP_W-1:0] SMP_LAST = SMP_W'(SAMPLES_PER_HALF - 1);

    // Count samples within the half line, restart on reload.
    always_ff @(posedge clk) begin
        if (!rst_n)                smp <= '0;
        else if (reload)           smp <= '0;
        else if (smp == SMP_LAST)  smp <= '0;
        else                       smp <= smp + SMP_W'(1);
    end

    // Last sample of a half line.
    assign hl_tick = (smp == SMP_LAST);

endmodule

// File: rtl/vft_halfline_ctr.sv
// Module: half-line position within a field, with wrap and trigger reload.
// Assumes field_len >= 32 so every trigger value lies inside the field.
module vft_halfline_ctr
    import vft_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reload,
    input  logic [TRIG_W-1:0] reload_val,
    input  logic              hl_tick,
    input  logic [HL_W-1:0]   field_len,
    output logic [HL_W-1:0]   half_line,
    output logic              wrap
);

    logic at_end;

    // At or past the last half line (covers a field length that shrank).
    assign at_end = (half_line >= field_len - HL_W'(1));

    // Natural end of field; a reload in the same cycle suppresses it.
    assign wrap = hl_tick & at_end & ~reload;

    // Step, wrap or reload the half-line position.
    always_ff @(posedge clk) begin
        if (!rst_n)        half_line <= '0;
        else if (reload)   half_line <= HL_W'(reload_val);
        else if (wrap)     half_line <= '0;
        else if (hl_tick)  half_line <= half_line + HL_W'(1);
    end

endmodule

// File: rtl/vft_field_state.sv
// Module: odd/even field flag and running field count.
// Assumes wrap is a one-cycle strobe at the natural end of a field.
module vft_field_state #(
    parameter int FIELD_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wrap,
    input  logic               interlaced,
    output logic               odd_field,
    output logic [FIELD_W-1:0] field_cnt
);

    // Invert parity on each interlaced field wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)                   odd_field <= 1'b0;
        else if (wrap && interlaced)  odd_field <= ~odd_field;
    end

    // Count every field wrap, modulo 2^FIELD_W.
    always_ff @(posedge clk) begin
        if (!rst_n)     field_cnt <= '0;
        else if (wrap)  field_cnt <= field_cnt + FIELD_W'(1);
    end

endmodule

// File: rtl/vid_field_timer.sv
// Module: top of the video field timing generator.
// Connects the reference edge detector, the sample divider, the half-line counter
// and the field state. Assumes all inputs are synchronous to clk.
module vid_field_timer
    import vft_pkg::*;
#(
    parameter int SAMPLES_PER_HALF = 432,
    parameter int FIELD_W          = 3,
    parameter int VBL_HALF_LINES   = 50,
    localparam int SMP_W = $clog2(SAMPLES_PER_HALF)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rate_60,
    input  logic [1:0]         fl_code,
    input  logic [TRIG_W-1:0]  vtrig,
    input  logic               vref_in,
    output logic [HL_W-1:0]    half_line,
    output logic [HL_W-2:0]    line_num,
    output logic [FIELD_W-1:0] field_cnt,
    output logic               field_start,
    output logic               odd_field,
    output logic               vblank
);

    logic             vref_rise;
    logic [SMP_W-1:0] smp;
    logic             hl_tick;
    logic             wrap;
    logic [HL_W-1:0]  field_len;

    // Field length from the rate select and length code.
    assign field_len = field_half_lines(rate_60, fl_code);

    vft_vref_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .vref_in   (vref_in),
        .vref_rise (vref_rise)
    );

    vft_sample_ctr #(.SAMPLES_PER_HALF(SAMPLES_PER_HALF)) u_smp (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  (vref_rise),
        .smp     (smp),
        .hl_tick (hl_tick)
    );

    vft_halfline_ctr u_hl (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload     (vref_rise),
        .reload_val (vtrig),
        .hl_tick    (hl_tick),
        .field_len  (field_len),
        .half_line  (half_line),
        .wrap       (wrap)
    );

    vft_field_state #(.FIELD_W(FIELD_W)) u_fs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wrap       (wrap),
        .interlaced (fl_code == FLEN_INTERLACED),
        .odd_field  (odd_field),
        .field_cnt  (field_cnt)
    );

    // Derived position flags.
    assign line_num    = half_line[HL_W-1:1];
    assign field_start = (half_line == '0) && (smp == '0);
    assign vblank      = (half_line < HL_W'(VBL_HALF_LINES));

endmodule

// File: rtl/vid_field_timer_chk.sv
// Module: assertion checker for vid_field_timer, attached by bind.
// Assumes VBL_HALF_LINES > 0.
module vid_field_timer_chk #(
    parameter int FIELD_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         fl_code,
    input logic [4:0]         vtrig,
    input logic               vref_rise,
    input logic [9:0]         half_line,
    input logic [8:0]         line_num,
    input logic [FIELD_W-1:0] field_cnt,
    input logic               field_start,
    input logic               odd_field,
    input logic               vblank
);

    AST_HL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        half_line <= 10'd625); // R10

    AST_RELOAD_LOADS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        vref_rise |=> (half_line == 10'($past(vtrig)))); // R8

    AST_PARITY_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (odd_field != $past(odd_field)) |-> field_start); // R3

    AST_NONINT_PARITY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_code != 2'b00) |=> $stable(odd_field)); // R4

    AST_RELOAD_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        vref_rise |=> $stable(field_cnt)); // R9

    AST_FCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (field_cnt != $past(field_cnt)) |-> (field_cnt == $past(field_cnt) + FIELD_W'(1))); // R6

    AST_START_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |-> (line_num == 9'd0)); // R2

    AST_START_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |-> vblank); // R7

endmodule

bind vid_field_timer vid_field_timer_chk #(.FIELD_W(FIELD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fl_code     (fl_code),
    .vtrig       (vtrig),
    .vref_rise   (vref_rise),
    .half_line   (half_line),
    .line_num    (line_num),
    .field_cnt   (field_cnt),
    .field_start (field_start),
    .odd_field   (odd_field),
    .vblank      (vblank)
);

// File: tb/vid_field_timer_tb_top.sv
// Directed bench for vid_field_timer: one task per scenario, sampled at negedge.
module vid_field_timer_tb_top;

    localparam int SPH = 4;
    localparam int FW  = 3;
    localparam int VBL = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rate_60 = 1'b0;
    logic [1:0]    fl_code = 2'b00;
    logic [4:0]    vtrig = 5'd0;
    logic          vref_in = 1'b0;
    logic [9:0]    half_line;
    logic [8:0]    line_num;
    logic [FW-1:0] field_cnt;
    logic          field_start;
    logic          odd_field;
    logic          vblank;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    vid_field_timer #(.SAMPLES_PER_HALF(SPH), .FIELD_W(FW), .VBL_HALF_LINES(VBL)) dut_i (
        .clk(clk), .rst_n(rst_n), .rate_60(rate_60), .fl_code(fl_code),
        .vtrig(vtrig), .vref_in(vref_in), .half_line(half_line), .line_num(line_num),
        .field_cnt(field_cnt), .field_start(field_start), .odd_field(odd_field),
        .vblank(vblank)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic restart(input logic r60, input logic [1:0] code, input logic [4:0] trig);
        @(negedge clk);
        rst_n = 1'b0; vref_in = 1'b0;
        rate_60 = r60; fl_code = code; vtrig = trig;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset;
        restart(1'b0, 2'b00, 5'd0);
        chk("R1 half_line", half_line, 0);
        chk("R1 line_num", line_num, 0);
        chk("R1 field_cnt", field_cnt, 0);
        chk("R1 odd_field", odd_field, 0);
        chk("R1 field_start", field_start, 1);
        chk("R1 vblank", vblank, 1);
    endtask

    task automatic t_step_and_blank;
        restart(1'b0, 2'b00, 5'd0);
        step(1);
        chk("R6 start low after origin", field_start, 0);
        step(SPH - 1);
        chk("R2 one half line", half_line, 1);
        step(SPH * (VBL - 2));
        chk("R7 blank at VBL-1", vblank, 1);
        step(SPH);
        chk("R7 blank off at VBL", vblank, 0);
        step(SPH * 11);
        chk("R2 half line 21", half_line, 21);
        chk("R2 line of 21", line_num, 10);
    endtask

    task automatic t_field(input logic r60, input logic [1:0] code, input int n_hl,
                           input int par_flip, input string req);
        restart(r60, code, 5'd0);
        step(n_hl * SPH - 1);
        chk({req, " last half line"}, half_line, n_hl - 1);
        chk({req, " no start before end"}, field_start, 0);
        step(1);
        chk({req, " wrap"}, half_line, 0);
        chk({req, " R6 start"}, field_start, 1);
        chk({req, " R6 count"}, field_cnt, 1);
        chk({req, " parity 1"}, odd_field, par_flip);
        step(n_hl * SPH);
        chk({req, " parity 2"}, odd_field, 0);
        chk({req, " R6 count 2"}, field_cnt, 2);
    endtask

    task automatic t_count_wrap;
        restart(1'b1, 2'b01, 5'd0);
        step(524 * SPH * 8);
        chk("R6 count wraps modulo", field_cnt, 0);
        chk("R6 start at wrap", field_start, 1);
    endtask

    task automatic t_reload;
        restart(1'b0, 2'b00, 5'd0);
        step(100);
        chk("R8 before reload", half_line, 25);
        vtrig = 5'd7;
        step(SPH);
        chk("R8 vtrig alone no effect", half_line, 26);
        vref_in = 1'b1;
        step(1);
        chk("R8 reload value", half_line, 7);
        vref_in = 1'b0;
        step((625 - 7) * SPH - 1);
        chk("R8 no start early", field_start, 0);
        step(1);
        chk("R8 start after N-vtrig", field_start, 1);
        chk("R8 parity after wrap", odd_field, 1);
        vtrig = 5'd31;
        vref_in = 1'b1;
        step(1);
        chk("R8 max trigger", half_line, 31);
        vref_in = 1'b0;
        vtrig = 5'd0;
        step(SPH * 3);
        vref_in = 1'b1;
        step(1);
        chk("R8 zero trigger origin", field_start, 1);
        chk("R8 zero trigger keeps parity", odd_field, 1);
        chk("R8 zero trigger keeps count", field_cnt, 1);
        vref_in = 1'b0;
    endtask

    task automatic t_collision;
        restart(1'b0, 2'b00, 5'd5);
        step(625 * SPH - 1);
        chk("R9 at last sample", half_line, 624);
        vref_in = 1'b1;
        step(1);
        chk("R9 reload wins", half_line, 5);
        chk("R9 parity kept", odd_field, 0);
        chk("R9 count kept", field_cnt, 0);
        step(SPH);
        chk("R8 held high no reload", half_line, 6);
        vref_in = 1'b0;
    endtask

    task automatic t_shrink;
        restart(1'b0, 2'b10, 5'd0);
        step(625 * SPH);
        chk("R10 long field past 624", half_line, 625);
        fl_code = 2'b01;
        step(SPH - 1);
        chk("R10 still at 625", half_line, 625);
        step(1);
        chk("R10 wraps on next step", half_line, 0);
        chk("R10 count", field_cnt, 1);
        chk("R10 parity non-interlaced", odd_field, 0);
    endtask

    initial begin
        t_reset();
        t_step_and_blank();
        t_field(1'b0, 2'b00, 625, 1, "R3 50Hz");
        t_field(1'b1, 2'b00, 525, 1, "R3 60Hz");
        t_field(1'b0, 2'b01, 624, 0, "R4 50Hz");
        t_field(1'b1, 2'b01, 524, 0, "R4 60Hz");
        t_field(1'b0, 2'b10, 626, 0, "R5 50Hz code10");
        t_field(1'b1, 2'b11, 526, 0, "R5 60Hz code11");
        t_count_wrap();
        t_reload();
        t_collision();
        t_shrink();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule